// File: doc/BRIEF.md
# ADC Status and Interrupt Control Register

This block is the CPU-visible control and status register of an analog-to-digital converter. It decodes one address on a simple bus with separate read and write strobes and 8-bit data. It stores the interrupt enable, a continuous-conversion enable and a 5-bit channel select. Every write asks the converter for a new conversion with a one-cycle start pulse, unless the written channel code is one of the unused codes, which mean that the converter is off.

The top bit has two roles, chosen by the interrupt enable. With interrupts off it is a read-only completion flag. The flag sets when a conversion finishes. In continuous mode it sets only on the first completion after the last register write. Any register write clears it, and so does a read of the converter's data register, which the converter reports on its own input. With interrupts on the same bit is an ordinary stored bit that chooses who services a conversion. A completion then raises a pending request, which appears on the CPU request output when the bit is 0 and on the DMA request output when it is 1. A register write or a data-register read clears the request.

Top module: `adc_ctl_reg`

## Requirements
- R1: After reset all eight register bits read as 0, and `irq_cpu`, `irq_dma` and `conv_start` are low.
- R2: A write at `CSR_ADDR` stores bit 6 (interrupt enable), bit 5 (continuous enable) and bits 4..0 (channel). A read at `CSR_ADDR` returns {bit7, enable, continuous, channel} on `bus_rdata` in the same cycle.
- R3: With interrupt enable 0 and continuous enable 0, every `conv_done` pulse sets bit 7 from the next clock edge.
- R4: With interrupt enable 0 and continuous enable 1, only the first `conv_done` after the last register write sets bit 7. Later pulses leave it at 0 until another write re-arms it.
- R5: With interrupt enable 0, a register write or a `data_rd` pulse clears bit 7, and a 1 written to bit 7 is ignored.
- R6: With interrupt enable 1, bit 7 takes the written value and holds it through conversions and data reads.
- R7: With interrupt enable 1, a `conv_done` pulse raises the request on the next edge: on `irq_cpu` when bit 7 is 0, on `irq_dma` when bit 7 is 1. The two outputs are never high together.
- R8: A register write or a `data_rd` pulse drops the pending request on the next edge.
- R9: When `conv_done` falls in the same cycle as a register write or a `data_rd` pulse, the clearing access wins, and neither bit 7 nor the request is set by that pulse.
- R10: `conv_start` is high for exactly the one cycle after a write whose channel field is below `NUM_CHAN` (16). Channel codes 16 to 31 give no pulse.
- R11: `bus_rdata` is 0 whenever no read at `CSR_ADDR` is in progress, and writes at other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| conv_done | input | 1 | One-cycle pulse at the end of a conversion |
| data_rd | input | 1 | Pulse when the CPU reads the converter data register |
| conv_start | output | 1 | One-cycle request for a new conversion |
| chan_sel | output | 5 | Selected channel |
| cont_mode | output | 1 | Continuous-conversion enable |
| irq_cpu | output | 1 | Conversion request routed to the CPU |
| irq_dma | output | 1 | Conversion request routed to DMA |

## Verification
A conversion-done pulse can arrive in the same cycle as a clearing access, either a register write or a data-register read. The bench drives these collisions on purpose in both modes of bit 7, and also produces them at random. The reference model applies the rule that the clear wins, and the bench compares the flag, the read-back and both request outputs against that model on every cycle.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  localparam int CSR_W      = 8;
  localparam int CSR_CHAN_W = 5;

  typedef struct packed {
    logic                  sel;   // completion flag or service select
    logic                  ien;
    logic                  cont;
    logic [CSR_CHAN_W-1:0] chan;
  } csr_t;

  function automatic logic chan_live(input logic [CSR_CHAN_W-1:0] code,
                                     input int unsigned num_chan);
    return (32'(code) < num_chan);
  endfunction

  function automatic logic [CSR_W-1:0] csr_pack(input csr_t c);
    return {c.sel, c.ien, c.cont, c.chan};
  endfunction

  function automatic csr_t csr_unpack(input logic [CSR_W-1:0] v);
    csr_t c;
    c.sel  = v[7];
    c.ien  = v[6];
    c.cont = v[5];
    c.chan = v[CSR_CHAN_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/adc_ctl_bus.sv
module adc_ctl_bus
  import adc_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = '0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  csr_t              csr_q,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic [CSR_W-1:0]  rdata
);

  logic sel_addr;

  always_comb begin
    sel_addr = (bus_addr == CSR_ADDR);
    wr_hit   = bus_wr && sel_addr;
    rd_hit   = bus_rd && sel_addr;
    rdata    = rd_hit ? csr_pack(csr_q) : '0;
  end

endmodule

// File: rtl/adc_ctl_flag.sv
module adc_ctl_flag
  import adc_ctl_pkg::*;
#(
  parameter int NUM_CHAN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  csr_t       wr_val,
  input  logic       data_rd,
  input  logic       conv_done,
  output csr_t       csr_q,
  output logic       conv_start,
  output logic       flag_set_evt
);

  localparam int CODES = 1 << CSR_CHAN_W;

  logic seen_q;
  logic live;
  csr_t csr_d;
  logic seen_d;

  generate
    if (NUM_CHAN >= CODES) begin : g_all_live
      assign live = 1'b1;
    end else begin : g_some_off
      assign live = chan_live(wr_val.chan, NUM_CHAN);
    end
  endgenerate

  // The flag may set only in flag mode, on a completion with no clearing
  // access in the same cycle, and in continuous mode only on the first one.
  assign flag_set_evt = conv_done && !wr_hit && !data_rd && !csr_q.ien &&
                        (!csr_q.cont || !seen_q);

  always_comb begin
    csr_d  = csr_q;
    seen_d = seen_q;
    if (wr_hit) begin
      csr_d.ien  = wr_val.ien;
      csr_d.cont = wr_val.cont;
      csr_d.chan = wr_val.chan;
      csr_d.sel  = wr_val.ien ? wr_val.sel : 1'b0;
      seen_d     = 1'b0;
    end else begin
      if (conv_done) seen_d = 1'b1;
      if (!csr_q.ien) begin
        if (data_rd)           csr_d.sel = 1'b0;
        else if (flag_set_evt) csr_d.sel = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q      <= '0;
      seen_q     <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      csr_q      <= csr_d;
      seen_q     <= seen_d;
      conv_start <= wr_hit && live;
    end
  end

endmodule

// File: rtl/adc_ctl_irq.sv
module adc_ctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic data_rd,
  input  logic conv_done,
  input  logic ien,
  input  logic route_dma,
  output logic irq_cpu,
  output logic irq_dma,
  output logic clr_evt
);

  logic pend_q;

  assign clr_evt = wr_hit || data_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (clr_evt)           pend_q <= 1'b0;
    else if (conv_done && ien)  pend_q <= 1'b1;
  end

  assign irq_cpu = pend_q && !route_dma;
  assign irq_dma = pend_q &&  route_dma;

endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10,
  parameter int NUM_CHAN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              conv_done,
  input  logic              data_rd,
  output logic              conv_start,
  output logic [4:0]        chan_sel,
  output logic              cont_mode,
  output logic              irq_cpu,
  output logic              irq_dma
);

  csr_t csr_q;
  logic wr_hit;
  logic rd_hit;
  logic ien;
  logic stat7;
  logic flag_set_evt;
  logic clr_evt;

  adc_ctl_bus #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_bus (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .csr_q    (csr_q),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .rdata    (bus_rdata)
  );

  adc_ctl_flag #(.NUM_CHAN(NUM_CHAN)) u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_hit       (wr_hit),
    .wr_val       (csr_unpack(bus_wdata)),
    .data_rd      (data_rd),
    .conv_done    (conv_done),
    .csr_q        (csr_q),
    .conv_start   (conv_start),
    .flag_set_evt (flag_set_evt)
  );

  adc_ctl_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .data_rd   (data_rd),
    .conv_done (conv_done),
    .ien       (csr_q.ien),
    .route_dma (csr_q.sel),
    .irq_cpu   (irq_cpu),
    .irq_dma   (irq_dma),
    .clr_evt   (clr_evt)
  );

  assign ien       = csr_q.ien;
  assign stat7     = csr_q.sel;
  assign chan_sel  = csr_q.chan;
  assign cont_mode = csr_q.cont;

endmodule

// File: rtl/adc_ctl_checker.sv
module adc_ctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_hit,
  input logic       data_rd,
  input logic       conv_done,
  input logic [7:0] bus_wdata,
  input logic       ien,
  input logic       stat7,
  input logic       irq_cpu,
  input logic       irq_dma,
  input logic       conv_start
);

  // R7: never both routes at once
  p_route_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_cpu && irq_dma));

  // R7: a request only appears after a completion
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cpu || irq_dma) |-> $past(conv_done));

  // R8 / R9: a clearing access leaves no request behind
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit || data_rd) |=> !(irq_cpu || irq_dma));

  // R3: the flag rises only after a completion
  p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat7) && !ien) |-> $past(conv_done));

  // R5: a write with interrupts off leaves bit 7 clear
  p_wr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[6]) |=> !stat7);

  // R5: a data read clears the flag
  p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !wr_hit && !ien) |=> !stat7);

  // R6: the select holds between writes
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && !wr_hit) |=> $stable(stat7));

  // R10: start pulses only follow a write
  p_start_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(wr_hit));

endmodule

bind adc_ctl_reg adc_ctl_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_hit     (wr_hit),
  .data_rd    (data_rd),
  .conv_done  (conv_done),
  .bus_wdata  (bus_wdata),
  .ien        (ien),
  .stat7      (stat7),
  .irq_cpu    (irq_cpu),
  .irq_dma    (irq_dma),
  .conv_start (conv_start)
);

// File: tb/adc_ctl_reg_test.sv
module adc_ctl_reg_test;

  localparam logic [7:0] A = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       conv_done = 1'b0;
  logic       data_rd = 1'b0;
  logic       conv_start;
  logic [4:0] chan_sel;
  logic       cont_mode;
  logic       irq_cpu;
  logic       irq_dma;

  adc_ctl_reg uut (.*);

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_ien, m_cont, m_chan, m_b7, m_seen, m_pend, m_start;

  always @(posedge clk) begin
    int hit;
    int w;
    if (!rst_n) begin
      m_ien = 0; m_cont = 0; m_chan = 0; m_b7 = 0;
      m_seen = 0; m_pend = 0; m_start = 0;
    end else begin
      hit = (bus_wr && bus_addr == A) ? 1 : 0;
      w = int'(bus_wdata);
      m_start = (hit != 0 && (w % 32) < 16) ? 1 : 0;
      if (hit != 0) begin
        m_ien = (w / 64) % 2; m_cont = (w / 32) % 2; m_chan = w % 32;
        m_b7 = (m_ien != 0) ? (w / 128) : 0;
        m_seen = 0; m_pend = 0;
      end else if (data_rd) begin
        if (m_ien == 0) m_b7 = 0;
        m_pend = 0;
        if (conv_done) m_seen = 1;
      end else if (conv_done) begin
        if (m_ien != 0) m_pend = 1;
        else if (m_cont == 0 || m_seen == 0) m_b7 = 1;
        m_seen = 1;
      end
    end
  end

  task automatic compare();
    int er;
    int ec;
    int ed;
    er = (bus_rd && bus_addr == A) ? (m_b7*128 + m_ien*64 + m_cont*32 + m_chan) : 0;
    ec = (m_pend != 0 && m_b7 == 0) ? 1 : 0;
    ed = (m_pend != 0 && m_b7 != 0) ? 1 : 0;
    n_chk++;
    if (int'(bus_rdata) != er || int'(irq_cpu) != ec || int'(irq_dma) != ed ||
        int'(conv_start) != m_start || int'(chan_sel) != m_chan ||
        int'(cont_mode) != m_cont) begin
      n_fail++;
      $display("FAIL %s: rdata=%h cpu=%0d dma=%0d start=%0d exp rdata=%h cpu=%0d dma=%0d start=%0d",
               cur_req, bus_rdata, irq_cpu, irq_dma, conv_start, er[7:0], ec, ed, m_start);
    end
  endtask

  // one bus cycle: drive at negedge, compare at the following negedge
  task automatic cyc(input logic wr, input logic [7:0] ad, input logic [7:0] wd,
                     input logic rd, input logic drd, input logic dn);
    bus_wr = wr; bus_addr = ad; bus_wdata = wd; bus_rd = rd;
    data_rd = drd; conv_done = dn;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();       cyc(0, A, 8'h00, 0, 0, 0); endtask
  task automatic wr(input logic [7:0] d); cyc(1, A, d, 0, 0, 0); endtask
  task automatic rd();         cyc(0, A, 8'h00, 1, 0, 0); endtask
  task automatic done();       cyc(0, A, 8'h00, 0, 0, 1); endtask
  task automatic drd();        cyc(0, A, 8'h00, 0, 1, 0); endtask

  task automatic expect8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: timeout, exp completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    rd();
    expect8("R1", bus_rdata, 8'h00);
    expect8("R1", {5'b0, irq_cpu, irq_dma, conv_start}, 8'h00);

    cur_req = "R2";
    wr(8'h25); rd();
    expect8("R2", bus_rdata, 8'h25);
    cur_req = "R11";
    cyc(1, 8'h11, 8'h7F, 0, 0, 0);
    cyc(0, 8'h11, 8'h00, 1, 0, 0);
    expect8("R11", bus_rdata, 8'h00);
    rd();
    expect8("R11", bus_rdata, 8'h25);

    cur_req = "R3";
    wr(8'h03); done(); rd();
    expect8("R3", bus_rdata, 8'h83);
    done(); done(); rd();
    cur_req = "R5";
    drd(); rd();
    expect8("R5", bus_rdata, 8'h03);
    done(); wr(8'h83); rd();
    expect8("R5", bus_rdata, 8'h03);

    cur_req = "R4";
    wr(8'h23); done(); rd();
    expect8("R4", bus_rdata, 8'hA3);
    drd(); done(); idle(); done(); rd();
    expect8("R4", bus_rdata, 8'h23);
    wr(8'h23); done(); rd();
    expect8("R4", bus_rdata, 8'hA3);

    cur_req = "R6";
    wr(8'hC3); done(); drd(); rd();
    expect8("R6", bus_rdata, 8'hC3);
    cur_req = "R7";
    wr(8'h43); done();
    expect8("R7", {6'b0, irq_cpu, irq_dma}, 8'h02);
    cur_req = "R8";
    drd();
    expect8("R8", {6'b0, irq_cpu, irq_dma}, 8'h00);
    cur_req = "R7";
    wr(8'hC3); done();
    expect8("R7", {6'b0, irq_cpu, irq_dma}, 8'h01);
    cur_req = "R8";
    wr(8'hC3);
    expect8("R8", {6'b0, irq_cpu, irq_dma}, 8'h00);

    cur_req = "R9";
    cyc(0, A, 8'h00, 0, 1, 1);
    expect8("R9", {6'b0, irq_cpu, irq_dma}, 8'h00);
    cyc(1, A, 8'h43, 0, 0, 1);
    expect8("R9", {6'b0, irq_cpu, irq_dma}, 8'h00);
    wr(8'h03); cyc(0, A, 8'h00, 1, 1, 1);
    rd();
    expect8("R9", bus_rdata, 8'h03);
    cyc(1, A, 8'h03, 0, 0, 1); rd();
    expect8("R9", bus_rdata, 8'h03);

    cur_req = "R10";
    wr(8'h1F);
    expect8("R10", {7'b0, conv_start}, 8'h00);
    wr(8'h0F);
    expect8("R10", {7'b0, conv_start}, 8'h01);
    idle();
    expect8("R10", {7'b0, conv_start}, 8'h00);

    cur_req = "R9";
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1] & r[2], r[3] ? A : 8'h11, r[15:8], r[4],
          r[5] & r[6], r[7] & r[16]);
    end

    idle();
    finish_up();
  end

endmodule